// File: doc/BRIEF.md
# Remote Echo Checker for a Serial Port

This block sits next to a UART transmitter and receiver and checks, without processor help, that a remote station echoes back every character that was sent. Each character handed to the local transmitter is also pushed into a short pending buffer. A small serial receiver watches the line that carries the echo. Each character it assembles is compared with the oldest pending entry. Up to two characters may be in flight, which covers a round trip of two character times.

The echo line is oversampled 16 times per bit. Each oversampling tick comes from an edge of the 16x transmit clock, and a 2-bit mode field picks which edge. The rising edge suits an echo that is aligned with the local bit clock. The falling edge suits a remote end that returns the data about half a clock phase late.

Any disagreement sets a sticky error bit in an 8-bit status word. This covers a data mismatch, a parity error, a bad stop bit, an echo that arrives with nothing pending, and a pending-buffer overflow. The error bit drives a level interrupt through an enable input. Software clears the bit by writing a one to that bit position.

Top module: `uart_echo_checker`

## Requirements
- R1: Mode values 00 and 11 disable checking. While disabled, the pending buffer is flushed, transmitted characters are not stored, echoes are ignored and no new error is raised. Checking that is enabled again starts with an empty buffer.
- R2: In mode 01 the echo line is sampled on rising edges of `tx_clk_i`. In mode 10 it is sampled on falling edges of `tx_clk_i`. Both modes check echoes correctly.
- R3: An echo equal to the oldest pending character removes that character and raises no error. Pending characters are matched in the order they were transmitted.
- R4: An echoed data byte that differs from the oldest pending character sets the error bit.
- R5: The echo frame is one start bit (0), DATA_W data bits LSB first, one parity bit and one stop bit (1). Parity is even by default, so the parity bit is the XOR of the data bits. A wrong parity bit sets the error bit even when the data matches.
- R6: A stop bit sampled as 0 sets the error bit.
- R7: An echo that completes while no character is pending sets the error bit.
- R8: Two characters may be pending without error. Transmitting a third before the first echo returns sets the error bit, and the extra character is not stored.
- R9: The error bit is status bit 3. It stays at 1 until a status write with data bit 3 equal to 1. A write with bit 3 equal to 0 leaves it unchanged. The other status bits read as 0.
- R10: When an error and a clearing write occur in the same cycle, the error bit ends up set.
- R11: `irq_o` is high exactly when the error bit is 1 and `irq_en_i` is 1.
- R12: After reset the error bit is 0, `irq_o` is 0 and the pending buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Check mode: 00 off, 01 rising edge, 10 falling edge, 11 off |
| irq_en_i | input | 1 | Interrupt enable |
| tx_clk_i | input | 1 | 16x transmit bit clock; the selected edge is one oversampling tick |
| tx_load_i | input | 1 | One-cycle strobe for a character handed to the transmitter |
| tx_data_i | input | DATA_W | Character being transmitted |
| rx_line_i | input | 1 | Serial line carrying the remote echo, idle high |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Status write data; bit 3 set clears the error |
| status_o | output | 8 | Status word, error at bit 3 |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted pending buffer shows up at the ports when the next echo completes. That is one character time after the fault: either a false error bit or a missing error on an echo that is wrong on purpose. A receiver that slips bit alignment or picks the wrong tick edge corrupts the assembled byte or its parity. The mismatch then reaches bit 3 of `status_o` two clocks after the mid-point of the stop bit. Faults in the error flag's priority or clear logic show within a cycle of the write. To make them visible, a clearing write is held across an error event and the bench watches whether the bit rises.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [1:0] {
    CHK_OFF  = 2'b00,
    CHK_RISE = 2'b01,
    CHK_FALL = 2'b10,
    CHK_RSVD = 2'b11
  } chk_mode_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } par_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  localparam int unsigned STAT_W  = 8;
  localparam int unsigned ERR_BIT = 3;
endpackage

// File: rtl/echo_tick.sv
module echo_tick
  import echo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       tx_clk_i,
  output logic       en_o,
  output logic       tick_o
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], tx_clk_i};
      prev_q <= sync_q[1];
    end
  end

  assign rise = sync_q[1] & ~prev_q;
  assign fall = ~sync_q[1] & prev_q;

  always_comb begin
    en_o   = 1'b0;
    tick_o = 1'b0;
    unique case (chk_mode_e'(mode_i))
      CHK_RISE: begin en_o = 1'b1; tick_o = rise; end
      CHK_FALL: begin en_o = 1'b1; tick_o = fall; end
      default:  begin en_o = 1'b0; tick_o = 1'b0; end
    endcase
  end

  // R1: no oversampling tick while checking is off
  a_r1_no_tick_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !tick_o);
endmodule

// File: rtl/echo_rx.sv
module echo_rx
  import echo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16,
  parameter par_e        PARITY = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int unsigned CNT_W   = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);
  localparam bit   HAS_PAR = (PARITY != PAR_NONE);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic [1:0]        sync_q;
  logic              line;
  logic              par_bad_q, frm_q, done_q;
  logic              exp_par;

  generate
    if (PARITY == PAR_ODD) begin : g_odd
      assign exp_par = ~^shreg_q;
    end else begin : g_even
      assign exp_par = ^shreg_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end
  assign line = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shreg_q   <= '0;
      par_bad_q <= 1'b0;
      frm_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!line) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
          RX_START: begin
            if (cnt_q == MID) begin
              cnt_q     <= '0;
              bit_q     <= '0;
              par_bad_q <= 1'b0;
              state_q   <= line ? RX_IDLE : RX_DATA; // false start filter
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              shreg_q <= {line, shreg_q[DATA_W-1:1]};
              if (bit_q == TOP) state_q <= HAS_PAR ? RX_PAR : RX_STOP;
              else              bit_q   <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q     <= '0;
              par_bad_q <= line ^ exp_par;
              state_q   <= RX_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              frm_q   <= ~line;
              done_q  <= 1'b1;
              state_q <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o    = done_q;
  assign data_o    = shreg_q;
  assign par_err_o = par_bad_q;
  assign frm_err_o = frm_q;

  // R3: one completion per frame
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_clr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_q == RX_IDLE));
endmodule

// File: rtl/echo_buf.sv
module echo_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              overflow_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, do_pop, do_push;

  assign empty_o    = (cnt_q == '0);
  assign full       = (cnt_q == CNT_MAX);
  assign do_pop     = pop_i & ~empty_o;
  assign do_push    = push_i & (~full | do_pop);
  assign overflow_o = push_i & full & ~do_pop;
  assign head_o     = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= push_data_i;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  a_r1_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  a_r8_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !flush_i |=> !empty_o);
endmodule

// File: rtl/echo_flag.sv
module echo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/uart_echo_checker.sv
module uart_echo_checker
  import echo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned OSR    = 16,
  parameter par_e        PARITY = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              irq_en_i,
  input  logic              tx_clk_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_line_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        status_o,
  output logic              irq_o
);
  logic              chk_en, tick;
  logic              rx_done, rx_par_err, rx_frm_err;
  logic [DATA_W-1:0] rx_data, head;
  logic              buf_empty, buf_ovf;
  logic              err_set, err_clr, err_q;
  logic              unused_wr;

  echo_tick u_tick (
    .clk_i, .rst_ni, .mode_i, .tx_clk_i,
    .en_o   (chk_en),
    .tick_o (tick)
  );

  echo_rx #(.DATA_W(DATA_W), .OSR(OSR), .PARITY(PARITY)) u_rx (
    .clk_i, .rst_ni,
    .clr_i     (~chk_en),
    .tick_i    (tick),
    .line_i    (rx_line_i),
    .done_o    (rx_done),
    .data_o    (rx_data),
    .par_err_o (rx_par_err),
    .frm_err_o (rx_frm_err)
  );

  echo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .flush_i     (~chk_en),
    .push_i      (tx_load_i & chk_en),
    .push_data_i (tx_data_i),
    .pop_i       (rx_done & chk_en),
    .head_o      (head),
    .empty_o     (buf_empty),
    .overflow_o  (buf_ovf)
  );

  always_comb begin
    err_set = 1'b0;
    if (chk_en) begin
      if (buf_ovf) err_set = 1'b1;
      if (rx_done) begin
        if (buf_empty || rx_data != head || rx_par_err || rx_frm_err)
          err_set = 1'b1;
      end
    end
  end

  assign err_clr   = wr_en_i & wr_data_i[ERR_BIT];
  assign unused_wr = ^{wr_data_i[7:ERR_BIT+1], wr_data_i[ERR_BIT-1:0]};

  echo_flag u_flag (
    .clk_i, .rst_ni,
    .set_i  (err_set),
    .clr_i  (err_clr),
    .flag_o (err_q)
  );

  always_comb begin
    status_o          = '0;
    status_o[ERR_BIT] = err_q;
  end
  assign irq_o = err_q & irq_en_i;

  a_r1_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_en |-> !err_set);
  a_r7_empty_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done && chk_en && buf_empty |=> status_o[ERR_BIT]);
  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) <= 1);
endmodule

// File: tb/uart_echo_checker_tb.sv
module uart_echo_checker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       irq_en = 1'b0;
  logic       tclk = 1'b0;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = '0;
  logic       line = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit m_err  = 1'b0;
  logic [7:0] m_q[$];
  bit hold = 1'b0;
  bit seen = 1'b0;
  bit run  = 1'b0;

  always #2 clk = ~clk;

  uart_echo_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .irq_en_i(irq_en),
    .tx_clk_i(tclk), .tx_load_i(tx_load), .tx_data_i(tx_data),
    .rx_line_i(line), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .status_o(status), .irq_o(irq)
  );

  initial forever begin
    repeat (4) @(posedge clk);
    tclk = ~tclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit enabled();
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

  // R11: checked every clock
  always @(negedge clk) if (run) chk("R11 irq", int'(irq), int'(status[3] & irq_en));
  always @(negedge clk) if (hold && status[3]) seen = 1'b1;

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk) mode = m;
    if (!enabled()) m_q.delete();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk);
    tx_load = 1'b1; tx_data = d;
    @(negedge clk);
    tx_load = 1'b0;
    if (enabled()) begin
      if (m_q.size() >= 2) m_err = 1'b1;
      else m_q.push_back(d);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic echo(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [10:0] frame;
    logic [7:0]  e;
    frame = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk) line = frame[i];
      repeat (127) @(negedge clk);
    end
    @(negedge clk) line = 1'b1;
    repeat (1600) @(negedge clk);
    if (enabled()) begin
      if (m_q.size() == 0) m_err = 1'b1;
      else begin
        e = m_q.pop_front();
        if (e != d) m_err = 1'b1;
      end
      if (bad_par || bad_stop) m_err = 1'b1;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (d[3]) m_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_err(input string req);
    chk(req, int'(status), int'({4'b0, m_err, 3'b0}));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 status after reset", int'(status), 0);
    chk("R12 irq after reset", int'(irq), 0);

    irq_en = 1'b1;
    set_mode(2'b01);
    send_tx(8'hA5); echo(8'hA5, 0, 0);
    chk_err("R2 R3 rising-edge match");

    send_tx(8'h3C); send_tx(8'h81);
    chk_err("R8 two pending allowed");
    echo(8'h3C, 0, 0); echo(8'h81, 0, 0);
    chk_err("R3 in-order match");

    send_tx(8'h55); echo(8'h54, 0, 0);
    chk_err("R4 mismatch");
    chk("R11 irq on error", int'(irq), 1);
    @(negedge clk) irq_en = 1'b0;
    @(negedge clk) chk("R11 irq masked", int'(irq), 0);
    irq_en = 1'b1;

    wr(8'hF7); chk_err("R9 write bit3=0 keeps");
    wr(8'h08); chk_err("R9 write bit3=1 clears");

    send_tx(8'h12); echo(8'h12, 1, 0);
    chk_err("R5 parity error");
    wr(8'h08);

    send_tx(8'h77); echo(8'h77, 0, 1);
    chk_err("R6 framing error");
    wr(8'h08); chk_err("R9 cleared after framing");

    echo(8'h99, 0, 0);
    chk_err("R7 echo with empty buffer");
    wr(8'h08);

    send_tx(8'h01); send_tx(8'h02); send_tx(8'h03);
    chk_err("R8 overflow");
    set_mode(2'b00); wr(8'h08);

    send_tx(8'h11); echo(8'h22, 0, 0);
    chk_err("R1 mode 00 ignores echo");
    set_mode(2'b11); echo(8'h22, 1, 0);
    chk_err("R1 mode 11 ignores echo");

    set_mode(2'b01); send_tx(8'h44);
    set_mode(2'b00); set_mode(2'b01);
    send_tx(8'h66); echo(8'h66, 0, 0);
    chk_err("R1 re-enable flushes buffer");

    set_mode(2'b10);
    send_tx(8'hC3); echo(8'hC3, 0, 0);
    chk_err("R2 falling-edge match");
    send_tx(8'hC3); echo(8'hC2, 0, 0);
    chk_err("R2 falling-edge mismatch");
    wr(8'h08);

    set_mode(2'b01);
    send_tx(8'h5A);
    @(negedge clk);
    hold = 1'b1; seen = 1'b0; wr_en = 1'b1; wr_data = 8'h08;
    echo(8'h5B, 0, 0);
    @(negedge clk);
    wr_en = 1'b0; hold = 1'b0;
    m_err = 1'b0;
    @(negedge clk);
    chk("R10 set beats clear", int'(seen), 1);
    chk_err("R10 cleared after hold");

    finish_run();
  end
endmodule